// File: doc/BRIEF.md
# Immediate Register Transfer Unit

This block executes the register-immediate class of a small word-oriented machine. Each accepted instruction brings a decoded opcode, a modifier and an operand value M that has already been indexed. The unit then updates one of eight registers: the accumulator A, the extension register X, or one of six index registers I1 to I6. M is a full signed data value and not a memory address, so its magnitude can reach the largest value a word can hold.

Words are in sign-magnitude form: one sign bit (1 = negative) and five 6-bit bytes, which give a 30-bit magnitude. Index registers keep a sign and two bytes (12 bits). The opcode selects the register. The modifier selects the operation: add M, subtract M, load M, or load M with its sign flipped. For these opcodes the modifier is never read as a field specifier. Arithmetic on A or X can overflow, and an overflow sets a sticky flag. Arithmetic on an index register is truncated and sets no flag.

An instruction is presented with `inValid` for one cycle. The register outputs show the result one clock later, and in that same cycle `done` is high.

Top module: `irt_unit`

## Requirements
- R1: The opcode picks the target register. Opcode 48 selects A, opcodes 49 to 54 select I1 to I6, and opcode 55 selects X. An instruction changes no register other than its target.
- R2: Modifier 2 loads M, both sign and magnitude, into the target. M may use the full 30-bit magnitude. Opcode 48 with modifier 3 and M = +2000 leaves A negative with bytes 00 00 00 31 16, most significant byte first.
- R3: Modifier 3 loads M with its sign bit inverted and the magnitude unchanged. Loading the negation of +0 gives -0.
- R4: Modifier 0 adds M to the target and modifier 1 subtracts M from it, using signed sign-magnitude arithmetic.
- R5: When an add or subtract gives a zero magnitude, the target keeps the sign it had before the operation.
- R6: On A or X, an add or subtract whose true magnitude exceeds 2^30-1 keeps the low 30 bits of the magnitude and sets `ovfFlag`. The flag never clears except at reset. Loads and operations on index registers leave it unchanged.
- R7: Index registers hold a sign and a 12-bit magnitude. Loads and arithmetic keep only the low 12 bits of the result magnitude and never touch `ovfFlag`.
- R8: An opcode outside 48 to 55, or a modifier above 3, changes no register and leaves `ovfFlag` unchanged. It raises `illegal` for one cycle, together with `done`.
- R9: `done` is high exactly in the cycle after each cycle with `inValid` high, and the new register values are visible in that same cycle. With no `inValid`, nothing changes.
- R10: After reset, all registers are +0, and `ovfFlag`, `done` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Instruction present this cycle |
| inOpcode | input | 6 | Decoded opcode |
| inMod | input | 6 | Modifier field |
| inSign | input | 1 | Sign of M (1 = negative) |
| inMag | input | 30 | Magnitude of M, five base-64 bytes |
| regA | output | 31 | Accumulator {sign, magnitude} |
| regX | output | 31 | Extension register {sign, magnitude} |
| regIdx | output | 78 | I1..I6, 13 bits each {sign, 12-bit magnitude}, I1 in the lowest bits |
| ovfFlag | output | 1 | Sticky overflow flag |
| done | output | 1 | Result pulse, one cycle after inValid |
| illegal | output | 1 | Illegal instruction pulse, aligned with done |

## Verification
A wrong stored value or a wrong sign in any register appears on its output port in the same cycle that `done` rises. The scoreboard therefore catches it at the first result after the faulty instruction, even when the error is only a -0 versus +0 difference. A flag that is set or cleared wrongly, or a write that lands in the wrong register, shows up in that same comparison, because every comparison covers all eight registers and the flag. A pulse that is stuck or misaligned is caught in the following cycle: either an unexpected `done` arrives with an empty queue, or expected items are still left in the queue at the end.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam int BYTE_W      = 6;
  localparam int WORD_BYTES  = 5;
  localparam int IDX_BYTES   = 2;
  localparam int NUM_IDX     = 6;
  localparam int MAG_W       = BYTE_W * WORD_BYTES;
  localparam int IDX_MAG_W   = BYTE_W * IDX_BYTES;
  localparam int IDX_W       = IDX_MAG_W + 1;
  localparam int WORD_W      = MAG_W + 1;
  localparam int NUM_REGS    = NUM_IDX + 2;
  localparam int SLOT_W      = $clog2(NUM_REGS);
  localparam int CODE_W      = BYTE_W;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
  } word_t;

  typedef enum logic [1:0] {
    OP_ADD     = 2'd0,
    OP_SUB     = 2'd1,
    OP_LOAD    = 2'd2,
    OP_LOADNEG = 2'd3
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              write;
    logic [SLOT_W-1:0] slot;
    op_e               op;
    logic              wide;
  } ctl_t;
endpackage

// File: rtl/irt_ctrl.sv
module irt_ctrl import irt_pkg::*; #(
  parameter int OPC_BASE = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CODE_W-1:0] inOpcode,
  input  logic [CODE_W-1:0] inMod,
  output ctl_t              ctl,
  output logic              done,
  output logic              illegal
);
  localparam logic [CODE_W-1:0] OPC_LO = CODE_W'(OPC_BASE);
  localparam logic [CODE_W-1:0] OPC_HI = CODE_W'(OPC_BASE + NUM_REGS - 1);
  localparam logic [CODE_W-1:0] MOD_MAX = CODE_W'(3);

  logic inRange;
  logic modOk;
  logic legal;
  logic [CODE_W-1:0] relCode;

  always_comb begin
    inRange = (inOpcode >= OPC_LO) && (inOpcode <= OPC_HI);
    modOk   = inMod <= MOD_MAX;
    legal   = inRange && modOk;
    relCode = inOpcode - OPC_LO;
    ctl.write = inValid && legal;
    ctl.slot  = relCode[SLOT_W-1:0];
    ctl.op    = op_e'(inMod[1:0]);
    ctl.wide  = (relCode[SLOT_W-1:0] == '0) ||
                (relCode[SLOT_W-1:0] == SLOT_W'(NUM_REGS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= inValid;
      illegal <= inValid && !legal;
    end
  end
endmodule

// File: rtl/irt_datapath.sv
module irt_datapath import irt_pkg::*; (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_t                     ctl,
  input  word_t                    mWord,
  output word_t                    outA,
  output word_t                    outX,
  output logic [NUM_IDX*IDX_W-1:0] outIdx,
  output logic                     ovfFlag
);
  word_t view [NUM_REGS];
  word_t cur;
  word_t res;
  logic  effSign;
  logic  sameSign;
  logic  magGe;
  logic  carry;
  logic [MAG_W:0] sumW;

  always_comb begin
    cur      = view[ctl.slot];
    effSign  = (ctl.op == OP_SUB || ctl.op == OP_LOADNEG) ? ~mWord.sign : mWord.sign;
    sameSign = (cur.sign == effSign);
    sumW     = {1'b0, cur.mag} + {1'b0, mWord.mag};
    magGe    = cur.mag >= mWord.mag;
    carry    = 1'b0;
    res      = '0;
    case (ctl.op)
      OP_LOAD, OP_LOADNEG: res = '{sign: effSign, mag: mWord.mag};
      default: begin
        if (sameSign) begin
          res   = '{sign: cur.sign, mag: sumW[MAG_W-1:0]};
          carry = sumW[MAG_W];
        end else if (magGe) begin
          // zero result lands here and keeps the old sign
          res = '{sign: cur.sign, mag: cur.mag - mWord.mag};
        end else begin
          res = '{sign: effSign, mag: mWord.mag - cur.mag};
        end
      end
    endcase
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    if (g == 0 || g == NUM_REGS - 1) begin : gWide
      word_t q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (ctl.write && ctl.slot == SLOT_W'(g)) q <= res;
      end
      assign view[g] = q;
    end else begin : gIdx
      logic [IDX_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (ctl.write && ctl.slot == SLOT_W'(g))
          q <= {res.sign, res.mag[IDX_MAG_W-1:0]};
      end
      assign view[g] = '{sign: q[IDX_W-1],
                         mag: {{(MAG_W-IDX_MAG_W){1'b0}}, q[IDX_MAG_W-1:0]}};
      assign outIdx[(g-1)*IDX_W +: IDX_W] = q;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= 1'b0;
    else if (ctl.write && ctl.wide && carry) ovfFlag <= 1'b1;
  end

  assign outA = view[0];
  assign outX = view[NUM_REGS-1];
endmodule

// File: rtl/irt_unit.sv
module irt_unit import irt_pkg::*; #(
  parameter int OPC_BASE = 48
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [CODE_W-1:0]        inOpcode,
  input  logic [CODE_W-1:0]        inMod,
  input  logic                     inSign,
  input  logic [MAG_W-1:0]         inMag,
  output logic [WORD_W-1:0]        regA,
  output logic [WORD_W-1:0]        regX,
  output logic [NUM_IDX*IDX_W-1:0] regIdx,
  output logic                     ovfFlag,
  output logic                     done,
  output logic                     illegal
);
  ctl_t  ctl;
  word_t mWord;
  word_t outA;
  word_t outX;

  assign mWord = '{sign: inSign, mag: inMag};

  irt_ctrl #(.OPC_BASE(OPC_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOpcode(inOpcode),
    .inMod(inMod), .ctl(ctl), .done(done), .illegal(illegal)
  );

  irt_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mWord(mWord),
    .outA(outA), .outX(outX), .outIdx(regIdx), .ovfFlag(ovfFlag)
  );

  assign regA = outA;
  assign regX = outX;
endmodule

// File: rtl/irt_unit_chk.sv
module irt_unit_chk import irt_pkg::*; #(
  parameter int OPC_BASE = 48
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic [CODE_W-1:0]        inOpcode,
  input logic [CODE_W-1:0]        inMod,
  input logic                     inSign,
  input logic [MAG_W-1:0]         inMag,
  input logic [WORD_W-1:0]        regA,
  input logic [WORD_W-1:0]        regX,
  input logic [NUM_IDX*IDX_W-1:0] regIdx,
  input logic                     ovfFlag,
  input logic                     done,
  input logic                     illegal
);
  localparam logic [CODE_W-1:0] OPC_A = CODE_W'(OPC_BASE);
  localparam logic [CODE_W-1:0] OPC_X = CODE_W'(OPC_BASE + NUM_REGS - 1);

  logic idxOp;
  assign idxOp = inValid && (inOpcode > OPC_A) && (inOpcode < OPC_X);

  a_r9_done_follows_valid: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> done);

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(regA) && $stable(regX) && $stable(regIdx) && $stable(ovfFlag)));

  a_r8_illegal_no_change: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> ($stable(regA) && $stable(regX) && $stable(regIdx) && $stable(ovfFlag)));

  a_r8_illegal_with_done: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);

  a_r2_load_a: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOpcode == OPC_A && inMod == CODE_W'(2)) |=> (regA == $past({inSign, inMag})));

  a_r3_loadneg_x: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOpcode == OPC_X && inMod == CODE_W'(3)) |=> (regX == {~$past(inSign), $past(inMag)}));

  a_r7_idx_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    idxOp |=> $stable(ovfFlag));
endmodule

bind irt_unit irt_unit_chk #(.OPC_BASE(OPC_BASE)) u_chk (.*);

// File: tb/sim_irt_unit.sv
module sim_irt_unit;
  timeunit 1ns;
  timeprecision 100ps;

  localparam longint MASK30 = (64'd1 << 30) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [5:0]  inOpcode = '0;
  logic [5:0]  inMod = '0;
  logic        inSign = 1'b0;
  logic [29:0] inMag = '0;
  logic [30:0] regA, regX;
  logic [77:0] regIdx;
  logic        ovfFlag, done, illegal;

  always #2.5 clk = ~clk;

  irt_unit u0 (.*);

  typedef struct {
    logic [30:0] a;
    logic [30:0] x;
    logic [77:0] idx;
    logic        ovf;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t   expQ[$];
  bit     mSign [8];
  longint mMag  [8];
  bit     mOvf;
  int     nChecks = 0;
  int     nFails  = 0;

  function automatic exp_t snap(bit ill, string tag);
    exp_t e;
    e.a = {mSign[0], mMag[0][29:0]};
    e.x = {mSign[7], mMag[7][29:0]};
    e.idx = '0;
    for (int k = 1; k <= 6; k++) e.idx[(k-1)*13 +: 13] = {mSign[k], mMag[k][11:0]};
    e.ovf = mOvf;
    e.ill = ill;
    e.tag = tag;
    return e;
  endfunction

  task automatic model(input int op, input int md, input bit s, input longint magIn, output bit ill);
    longint mag;
    longint rv;
    longint nm;
    bit ns;
    bit es;
    int slot;
    bit isIdx;
    mag = magIn & MASK30;
    ill = 1'b0;
    if (op < 48 || op > 55 || md > 3) begin
      ill = 1'b1;
      return;
    end
    slot = op - 48;
    isIdx = (slot >= 1 && slot <= 6);
    if (md >= 2) begin
      ns = (md == 3) ? ~s : s;
      nm = mag;
    end else begin
      es = s ^ (md == 1);
      rv = (mSign[slot] ? -mMag[slot] : mMag[slot]) + (es ? -mag : mag);
      if (rv == 0) begin
        ns = mSign[slot];
        nm = 0;
      end else begin
        ns = (rv < 0);
        nm = (rv < 0) ? -rv : rv;
      end
      if (!isIdx && nm > MASK30) begin
        mOvf = 1'b1;
        nm = nm & MASK30;
      end
    end
    if (isIdx) nm = nm & 4095;
    mSign[slot] = ns;
    mMag[slot] = nm;
  endtask

  task automatic issue(input int op, input int md, input bit s, input longint mag, input string tag);
    bit ill;
    @(negedge clk);
    inValid  = 1'b1;
    inOpcode = op[5:0];
    inMod    = md[5:0];
    inSign   = s;
    inMag    = mag[29:0];
    model(op, md, s, mag, ill);
    expQ.push_back(snap(ill, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic cmpNow(input string tag);
    exp_t e;
    e = snap(1'b0, tag);
    nChecks++;
    if (regA !== e.a || regX !== e.x || regIdx !== e.idx || ovfFlag !== e.ovf || done !== 1'b0) begin
      nFails++;
      $display("FAIL %s: A=%h/%h X=%h/%h idx=%h/%h ovf=%b/%b done=%b/0",
               tag, regA, e.a, regX, e.x, regIdx, e.idx, ovfFlag, e.ovf, done);
    end
  endtask

  // monitor: pop one expected item for every done pulse
  always @(negedge clk) begin
    exp_t e;
    if (rstN && done) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R9: unexpected done actual=1 expected=0");
      end else begin
        e = expQ.pop_front();
        if (regA !== e.a || regX !== e.x || regIdx !== e.idx || ovfFlag !== e.ovf || illegal !== e.ill) begin
          nFails++;
          $display("FAIL %s: A=%h/%h X=%h/%h idx=%h/%h ovf=%b/%b illegal=%b/%b",
                   e.tag, regA, e.a, regX, e.x, regIdx, e.idx, ovfFlag, e.ovf, illegal, e.ill);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    longint seed;
    for (int k = 0; k < 8; k++) begin
      mSign[k] = 0;
      mMag[k] = 0;
    end
    mOvf = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    nChecks++;
    if (regA !== '0 || regX !== '0 || regIdx !== '0 || ovfFlag !== 0 || done !== 0 || illegal !== 0) begin
      nFails++;
      $display("FAIL R10: A=%h X=%h idx=%h ovf=%b done=%b ill=%b expected all 0",
               regA, regX, regIdx, ovfFlag, done, illegal);
    end
    rstN = 1'b1;
    idle(2);

    // R2: negated load of 2000 into A
    issue(48, 3, 0, 2000, "R2 A <- -2000");
    idle(2);
    nChecks++;
    if (regA !== {1'b1, 6'd0, 6'd0, 6'd0, 6'd31, 6'd16}) begin
      nFails++;
      $display("FAIL R2: A=%h expected=%h", regA, {1'b1, 6'd0, 6'd0, 6'd0, 6'd31, 6'd16});
    end

    issue(55, 2, 0, MASK30, "R2 X <- max magnitude");
    issue(49, 2, 0, 5000, "R7 I1 load truncated");
    issue(50, 3, 0, 0, "R3 I2 <- -0");
    issue(55, 3, 0, 0, "R3 X <- -0");

    // R4 / R5 arithmetic on A
    issue(48, 2, 0, 100, "R4 A <- 100");
    issue(48, 0, 1, 30, "R4 A + (-30)");
    issue(48, 1, 0, 200, "R4 A - 200");
    issue(48, 0, 0, 130, "R5 A zero keeps minus");
    issue(48, 1, 1, 0, "R5 A - (-0) keeps minus");
    issue(55, 1, 1, 77, "R4 X - (-77)");

    // R1 each index register
    for (int k = 1; k <= 6; k++) issue(48 + k, 2, k[0], longint'(k * 7 + 1000), "R1 index select");
    issue(55, 2, 0, 4242, "R1 X select");

    // R7 index truncation without flag
    issue(51, 2, 0, 4095, "R7 I3 <- 4095");
    issue(51, 0, 0, 1, "R7 I3 wraps no flag");
    issue(52, 1, 0, 2000, "R7 I4 goes negative");
    issue(53, 0, 0, MASK30, "R7 I5 big add truncated");

    // R8 illegal codes
    issue(47, 2, 0, 5, "R8 opcode 47");
    issue(56, 2, 0, 5, "R8 opcode 56");
    issue(48, 4, 0, 5, "R8 modifier 4");
    issue(53, 63, 1, 9, "R8 modifier 63");

    // R9 idle
    idle(6);
    cmpNow("R9 idle no change");

    // R6 overflow on A and X
    issue(48, 2, 0, MASK30, "R6 A <- max");
    issue(48, 0, 0, 1, "R6 A overflow");
    issue(48, 2, 0, 9, "R6 flag sticky over load");
    issue(55, 2, 1, MASK30, "R6 X <- -max");
    issue(55, 1, 0, 5, "R6 X negative overflow");

    // R4 mixed sequence
    seed = 64'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      int op;
      int md;
      longint mg;
      seed = (seed * 64'd6364136223846793005 + 64'd1442695040888963407);
      op = 48 + int'(seed[40:38]);
      if (seed[20:16] == 0) op = 47 + 10 * int'(seed[21]);
      md = int'(seed[45:44]);
      if (seed[12:9] == 0) md = 4 + int'(seed[8:7]);
      mg = seed[50] ? (longint'(seed[61:32]) & MASK30) : longint'(seed[58:46]);
      issue(op, md, seed[5], mg, "R4 mixed sequence");
    end
    idle(4);
    cmpNow("R9 final idle");
    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R9: pending results actual=%0d expected=0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule